// File: doc/BRIEF.md
# 64-bit SEC-DED ECC Codec

This block computes an 8-bit check byte for a 64-bit word, and in the same cycle decodes that word against a stored check byte. The word arrives as two 32-bit halves. The check bits come from a fixed, irregular parity-check matrix. Each check bit is the parity of a masked subset of the high half and a masked subset of the low half.

On the decode side the block XORs the recomputed check byte with the stored byte to form the syndrome. It then searches the 64 data-bit columns of the matrix for a match. When one column matches, that data bit is inverted. When no column matches and exactly one syndrome bit is set, the named check bit is inverted. Any other nonzero syndrome is reported as uncorrectable, and the word passes through unchanged.

A parameter chooses between purely combinational outputs and one register stage that is cleared by reset. A memory controller instantiates the block in its write path to produce check bits and in its read path to scrub returned data.

Top module: `secded64_codec`

## Requirements
- R1: Check bit i of `check_out` is the XOR-reduction of (`data_hi` AND H[i]) XOR (`data_lo` AND L[i]), where bit j of a mask selects bit j of its half. The eight mask pairs (H[i], L[i]) for i = 7 down to 0 are: (ffff1111, 22221114), (8888ffff, 11118882), (44448888, ffff4441), (22224444, 8888222f), (11113333, 7777000f), (0f0f0f0f, 0f0fff00), (00ff00ff, 00fff0ff), (f00fe11e, c33c0ff7).
- R2: `syndrome` equals `check_out` XOR `ecc_in`. When it is zero, `single_err` and `multi_err` are low and the corrected outputs equal the inputs.
- R3: The column code of data bit b (bit index in {`data_hi`,`data_lo`}) takes its bit i from bit (b mod 32) of L[i] when b < 32 and from bit (b mod 32) of H[i] when b >= 32. A syndrome equal to that code inverts data bit b only, and sets `bad_data_vld`, `bad_data_bit` = b and `single_err`. A data-column match takes priority over check-bit correction.
- R4: When no data column matches and the syndrome has exactly one bit k set, check bit k alone is inverted in `ecc_out`, the data passes unchanged, and `bad_ecc_vld`, `bad_ecc_bit` = k and `single_err` are set.
- R5: A nonzero syndrome that matches no data column and has two or more bits set raises `multi_err`. Data and check byte then pass unchanged and both valid flags stay low. This is how flips of two bits are detected.
- R6: `single_err` and `multi_err` are never high together. `bad_data_bit` is 0 when `bad_data_vld` is low, and `bad_ecc_bit` is 0 when `bad_ecc_vld` is low.
- R7: With OUT_REG = 1 every output shows the decode of the inputs present at the previous rising clock edge. While `rst_n` is low every output is 0. With OUT_REG = 0 the outputs follow the inputs combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low asynchronous reset of the output stage |
| data_hi | input | 32 | Upper half of the word, bits 63..32 |
| data_lo | input | 32 | Lower half of the word, bits 31..0 |
| ecc_in | input | 8 | Stored check byte to decode against |
| check_out | output | 8 | Check byte computed over the input word |
| syndrome | output | 8 | check_out XOR ecc_in |
| data_out_hi | output | 32 | Corrected upper half |
| data_out_lo | output | 32 | Corrected lower half |
| ecc_out | output | 8 | Corrected check byte |
| single_err | output | 1 | One bit was located and corrected |
| multi_err | output | 1 | Nonzero syndrome that cannot be located |
| bad_data_bit | output | 6 | Index of the corrected data bit |
| bad_data_vld | output | 1 | bad_data_bit is meaningful |
| bad_ecc_bit | output | 3 | Index of the corrected check bit |
| bad_ecc_vld | output | 1 | bad_ecc_bit is meaningful |

## Verification
The assertions assume that the inputs are known values and that they settle between clock edges. The bench changes `data_hi`, `data_lo` and `ecc_in` only on falling edges, and never drives them to X. The register-delay property also assumes one full clock has passed since reset was released. It uses a flag that is set on the first edge after reset so that it never compares against a value loaded during reset. The stimulus comes from computed encodings with one or two chosen bits flipped, so every syndrome falls into one of the classes R2 to R5 define.

// File: rtl/secded64_pkg.sv
package secded64_pkg;

  localparam int DW  = 64;
  localparam int HW  = DW / 2;
  localparam int CW  = 8;
  localparam int IW  = $clog2(DW);
  localparam int CIW = $clog2(CW);

  typedef logic [HW-1:0] half_t;
  typedef logic [CW-1:0] chk_t;
  typedef logic [DW-1:0] word_t;

  typedef struct packed {
    chk_t            chk;
    chk_t            syn;
    half_t           hi;
    half_t           lo;
    chk_t            ecc;
    logic            sbe;
    logic            ube;
    logic [IW-1:0]   dbit;
    logic            dvld;
    logic [CIW-1:0]  cbit;
    logic            cvld;
  } result_t;

  // Mask applied to the upper half for check bit i
  function automatic half_t mask_upper(int i);
    case (i)
      0: return 32'hf00fe11e;
      1: return 32'h00ff00ff;
      2: return 32'h0f0f0f0f;
      3: return 32'h11113333;
      4: return 32'h22224444;
      5: return 32'h44448888;
      6: return 32'h8888ffff;
      default: return 32'hffff1111;
    endcase
  endfunction

  // Mask applied to the lower half for check bit i
  function automatic half_t mask_lower(int i);
    case (i)
      0: return 32'hc33c0ff7;
      1: return 32'h00fff0ff;
      2: return 32'h0f0fff00;
      3: return 32'h7777000f;
      4: return 32'h8888222f;
      5: return 32'hffff4441;
      6: return 32'h11118882;
      default: return 32'h22221114;
    endcase
  endfunction

  // Parity of one check bit over both halves
  function automatic logic parity_bit(int i, half_t hi, half_t lo);
    return (^(hi & mask_upper(i))) ^ (^(lo & mask_lower(i)));
  endfunction

  // Syndrome pattern produced by a flip of data bit b
  function automatic chk_t column_code(int b);
    chk_t  c;
    half_t m;
    for (int i = 0; i < CW; i++) begin
      m    = (b < HW) ? mask_lower(i) : mask_upper(i);
      c[i] = m[b % HW];
    end
    return c;
  endfunction

endpackage

// File: rtl/secded64_enc.sv
module secded64_enc
  import secded64_pkg::*;
(
  input  half_t hi,
  input  half_t lo,
  output chk_t  chk
);

  for (genvar i = 0; i < CW; i++) begin : g_row
    localparam half_t MH = mask_upper(i);
    localparam half_t ML = mask_lower(i);
    assign chk[i] = (^(hi & MH)) ^ (^(lo & ML));
  end

endmodule

// File: rtl/secded64_locate.sv
module secded64_locate
  import secded64_pkg::*;
(
  input  chk_t            syn,
  output logic [IW-1:0]   dbit,
  output logic            dvld,
  output logic [CIW-1:0]  cbit,
  output logic            cvld,
  output logic            ube
);

  word_t col_hit;

  for (genvar b = 0; b < DW; b++) begin : g_col
    localparam chk_t COL = column_code(b);
    assign col_hit[b] = (syn == COL);
  end

  // Lowest matching column wins
  always_comb begin
    dbit = '0;
    dvld = 1'b0;
    for (int b = DW - 1; b >= 0; b--) begin
      if (col_hit[b]) begin
        dbit = IW'(b);
        dvld = 1'b1;
      end
    end
  end

  logic syn_single;
  assign syn_single = $onehot(syn);

  always_comb begin
    cbit = '0;
    for (int k = CW - 1; k >= 0; k--) begin
      if (syn[k]) cbit = CIW'(k);
    end
    if (!(syn_single && !dvld)) cbit = '0;
  end

  assign cvld = syn_single && !dvld;
  assign ube  = (syn != '0) && !dvld && !syn_single;

endmodule

// File: rtl/secded64_fix.sv
module secded64_fix
  import secded64_pkg::*;
(
  input  half_t           hi,
  input  half_t           lo,
  input  chk_t            ecc,
  input  logic [IW-1:0]   dbit,
  input  logic            dvld,
  input  logic [CIW-1:0]  cbit,
  input  logic            cvld,
  output half_t           cor_hi,
  output half_t           cor_lo,
  output chk_t            cor_ecc
);

  word_t data_flip;
  chk_t  ecc_flip;

  always_comb begin
    data_flip = '0;
    if (dvld) data_flip[dbit] = 1'b1;
    ecc_flip = '0;
    if (cvld) ecc_flip[cbit] = 1'b1;
  end

  assign {cor_hi, cor_lo} = {hi, lo} ^ data_flip;
  assign cor_ecc          = ecc ^ ecc_flip;

endmodule

// File: rtl/secded64_codec.sv
module secded64_codec
  import secded64_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HW-1:0]     data_hi,
  input  logic [HW-1:0]     data_lo,
  input  logic [CW-1:0]     ecc_in,
  output logic [CW-1:0]     check_out,
  output logic [CW-1:0]     syndrome,
  output logic [HW-1:0]     data_out_hi,
  output logic [HW-1:0]     data_out_lo,
  output logic [CW-1:0]     ecc_out,
  output logic              single_err,
  output logic              multi_err,
  output logic [IW-1:0]     bad_data_bit,
  output logic              bad_data_vld,
  output logic [CIW-1:0]    bad_ecc_bit,
  output logic              bad_ecc_vld
);

  // Named internal events, visible to the bound checker
  chk_t            chk_w;
  chk_t            syn_w;
  logic [IW-1:0]   dbit_w;
  logic            dvld_w;
  logic [CIW-1:0]  cbit_w;
  logic            cvld_w;
  logic            ube_w;
  logic            sbe_w;
  half_t           cor_hi_w;
  half_t           cor_lo_w;
  chk_t            cor_ecc_w;

  secded64_enc u_enc (
    .hi  (data_hi),
    .lo  (data_lo),
    .chk (chk_w)
  );

  assign syn_w = chk_w ^ ecc_in;

  secded64_locate u_loc (
    .syn  (syn_w),
    .dbit (dbit_w),
    .dvld (dvld_w),
    .cbit (cbit_w),
    .cvld (cvld_w),
    .ube  (ube_w)
  );

  assign sbe_w = dvld_w | cvld_w;

  secded64_fix u_fix (
    .hi      (data_hi),
    .lo      (data_lo),
    .ecc     (ecc_in),
    .dbit    (dbit_w),
    .dvld    (dvld_w),
    .cbit    (cbit_w),
    .cvld    (cvld_w),
    .cor_hi  (cor_hi_w),
    .cor_lo  (cor_lo_w),
    .cor_ecc (cor_ecc_w)
  );

  result_t res_d;
  result_t res_q;

  always_comb begin
    res_d.chk  = chk_w;
    res_d.syn  = syn_w;
    res_d.hi   = cor_hi_w;
    res_d.lo   = cor_lo_w;
    res_d.ecc  = cor_ecc_w;
    res_d.sbe  = sbe_w;
    res_d.ube  = ube_w;
    res_d.dbit = dbit_w;
    res_d.dvld = dvld_w;
    res_d.cbit = cbit_w;
    res_d.cvld = cvld_w;
  end

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) res_q <= '0;
      else        res_q <= res_d;
    end
  end else begin : g_comb
    assign res_q = res_d;
  end

  assign check_out    = res_q.chk;
  assign syndrome     = res_q.syn;
  assign data_out_hi  = res_q.hi;
  assign data_out_lo  = res_q.lo;
  assign ecc_out      = res_q.ecc;
  assign single_err   = res_q.sbe;
  assign multi_err    = res_q.ube;
  assign bad_data_bit = res_q.dbit;
  assign bad_data_vld = res_q.dvld;
  assign bad_ecc_bit  = res_q.cbit;
  assign bad_ecc_vld  = res_q.cvld;

endmodule

// File: rtl/secded64_codec_chk.sv
module secded64_codec_chk
  import secded64_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input logic            clk,
  input logic            rst_n,
  input half_t           data_hi,
  input half_t           data_lo,
  input chk_t            ecc_in,
  input chk_t            syn_w,
  input half_t           cor_hi_w,
  input half_t           cor_lo_w,
  input chk_t            cor_ecc_w,
  input logic            dvld_w,
  input logic            cvld_w,
  input logic            sbe_w,
  input logic            ube_w,
  input half_t           data_out_hi,
  input logic            single_err,
  input logic            multi_err,
  input logic [IW-1:0]   bad_data_bit,
  input logic            bad_data_vld,
  input logic [CIW-1:0]  bad_ecc_bit,
  input logic            bad_ecc_vld
);

  AST_CLEAN_ON_ZERO_SYN: assert property (@(posedge clk) disable iff (!rst_n)
    (syn_w == '0) |-> (!sbe_w && !ube_w && cor_hi_w == data_hi && cor_lo_w == data_lo && cor_ecc_w == ecc_in)); // R2

  AST_DATA_ONE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    dvld_w |-> ($countones({cor_hi_w ^ data_hi, cor_lo_w ^ data_lo}) == 1 && cor_ecc_w == ecc_in)); // R3

  AST_CHECK_ONE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    cvld_w |-> ($countones(cor_ecc_w ^ ecc_in) == 1 && $countones(syn_w) == 1 && cor_hi_w == data_hi && cor_lo_w == data_lo)); // R4

  AST_UNCORR_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    ube_w |-> (!dvld_w && !cvld_w && cor_hi_w == data_hi && cor_lo_w == data_lo && cor_ecc_w == ecc_in)); // R5

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(single_err && multi_err)); // R6

  AST_DATA_IDX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bad_data_vld |-> (bad_data_bit == '0)); // R6

  AST_CHECK_IDX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bad_ecc_vld |-> (bad_ecc_bit == '0)); // R6

  if (OUT_REG) begin : g_lat
    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
    end

    AST_ONE_CYCLE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> (single_err == $past(sbe_w) && multi_err == $past(ube_w) && data_out_hi == $past(cor_hi_w))); // R7
  end

endmodule

bind secded64_codec secded64_codec_chk #(.OUT_REG(OUT_REG)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .data_hi      (data_hi),
  .data_lo      (data_lo),
  .ecc_in       (ecc_in),
  .syn_w        (syn_w),
  .cor_hi_w     (cor_hi_w),
  .cor_lo_w     (cor_lo_w),
  .cor_ecc_w    (cor_ecc_w),
  .dvld_w       (dvld_w),
  .cvld_w       (cvld_w),
  .sbe_w        (sbe_w),
  .ube_w        (ube_w),
  .data_out_hi  (data_out_hi),
  .single_err   (single_err),
  .multi_err    (multi_err),
  .bad_data_bit (bad_data_bit),
  .bad_data_vld (bad_data_vld),
  .bad_ecc_bit  (bad_ecc_bit),
  .bad_ecc_vld  (bad_ecc_vld)
);

// File: tb/secded64_codec_tb.sv
module secded64_codec_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] data_hi = '0;
  logic [31:0] data_lo = '0;
  logic [7:0]  ecc_in = '0;
  logic [7:0]  check_out, syndrome, ecc_out;
  logic [31:0] data_out_hi, data_out_lo;
  logic        single_err, multi_err, bad_data_vld, bad_ecc_vld;
  logic [5:0]  bad_data_bit;
  logic [2:0]  bad_ecc_bit;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  secded64_codec u_dut (
    .clk(clk), .rst_n(rst_n), .data_hi(data_hi), .data_lo(data_lo), .ecc_in(ecc_in),
    .check_out(check_out), .syndrome(syndrome), .data_out_hi(data_out_hi),
    .data_out_lo(data_out_lo), .ecc_out(ecc_out), .single_err(single_err),
    .multi_err(multi_err), .bad_data_bit(bad_data_bit), .bad_data_vld(bad_data_vld),
    .bad_ecc_bit(bad_ecc_bit), .bad_ecc_vld(bad_ecc_vld)
  );

  // Row i of the parity matrix as a 64-bit mask over {data_hi, data_lo}
  function automatic logic [63:0] row(int i);
    case (i)
      0: return 64'hf00fe11e_c33c0ff7;
      1: return 64'h00ff00ff_00fff0ff;
      2: return 64'h0f0f0f0f_0f0fff00;
      3: return 64'h11113333_7777000f;
      4: return 64'h22224444_8888222f;
      5: return 64'h44448888_ffff4441;
      6: return 64'h8888ffff_11118882;
      default: return 64'hffff1111_22221114;
    endcase
  endfunction

  function automatic logic [7:0] ref_check(logic [63:0] w);
    logic [7:0] c = '0;
    for (int i = 0; i < 8; i++) begin
      logic [63:0] r = row(i);
      for (int j = 0; j < 64; j++) if (r[j]) c[i] = c[i] ^ w[j];
    end
    return c;
  endfunction

  function automatic logic [7:0] ref_col(int b);
    logic [7:0] c;
    for (int i = 0; i < 8; i++) begin
      logic [63:0] r = row(i);
      c[i] = r[b];
    end
    return c;
  endfunction

  // Expected outputs packed as check,syn,data,ecc,sbe,ube,dbit,dvld,cbit,cvld
  function automatic logic [100:0] ref_decode(logic [63:0] w, logic [7:0] e);
    logic [7:0]  c = ref_check(w);
    logic [7:0]  s = c ^ e;
    logic [63:0] dw = w;
    logic [7:0]  de = e;
    logic [5:0]  db = '0;
    logic        dv = 1'b0;
    logic [2:0]  cb = '0;
    logic        cv = 1'b0;
    logic        ue = 1'b0;
    int          ones = 0;
    for (int b = 63; b >= 0; b--) if (s != 8'h00 && ref_col(b) == s) begin db = 6'(b); dv = 1'b1; end
    for (int k = 0; k < 8; k++) ones += int'(s[k]);
    if (dv) dw[db] = ~dw[db];
    else if (ones == 1) begin
      for (int k = 0; k < 8; k++) if (s[k]) cb = 3'(k);
      cv = 1'b1;
      de[cb] = ~de[cb];
    end else if (ones > 1) ue = 1'b1;
    return {c, s, dw, de, dv | cv, ue, db, dv, cb, cv};
  endfunction

  function automatic logic [100:0] dut_vec();
    return {check_out, syndrome, data_out_hi, data_out_lo, ecc_out, single_err, multi_err,
            bad_data_bit, bad_data_vld, bad_ecc_bit, bad_ecc_vld};
  endfunction

  task automatic check_vec(string req, logic [100:0] exp);
    n_checks++;
    if (dut_vec() !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, dut_vec(), exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, sample at the next falling edge
  task automatic apply(logic [63:0] w, logic [7:0] e);
    @(negedge clk);
    {data_hi, data_lo} = w;
    ecc_in = e;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    {data_hi, data_lo} = 64'h0123_4567_89ab_cdef;
    ecc_in = 8'h5a;
    repeat (3) @(negedge clk);
    check_vec("R7 reset", '0);
    rst_n = 1'b1;
  endtask

  task automatic t_encode();
    logic [63:0] pat [6] = '{64'h0, 64'hffff_ffff_ffff_ffff, 64'h0000_0000_0000_0001,
                             64'h8000_0000_0000_0000, 64'hdead_beef_0bad_f00d, 64'h5555_aaaa_3333_cccc};
    for (int p = 0; p < 6; p++) begin
      apply(pat[p], ref_check(pat[p]));
      check_vec("R1 R2 clean word", ref_decode(pat[p], ref_check(pat[p])));
    end
    for (int b = 0; b < 64; b++) begin
      logic [63:0] w = 64'h1 << b;
      apply(w, 8'h00);
      n_checks++;
      if (check_out !== ref_check(w)) begin
        n_errors++;
        $display("FAIL R1 walking one %0d: actual=%h expected=%h", b, check_out, ref_check(w));
      end
    end
  endtask

  task automatic t_data_flips(logic [63:0] base);
    logic [7:0] e = ref_check(base);
    for (int b = 0; b < 64; b++) begin
      logic [63:0] w = base ^ (64'h1 << b);
      logic [100:0] exp = ref_decode(w, e);
      apply(w, e);
      check_vec("R3 data flip", exp);
      n_checks++;
      if ({data_out_hi, data_out_lo} !== base || bad_data_bit !== 6'(b) || !single_err) begin
        n_errors++;
        $display("FAIL R3 bit %0d: actual=%h idx=%0d expected=%h idx=%0d", b,
                 {data_out_hi, data_out_lo}, bad_data_bit, base, b);
      end
    end
  endtask

  task automatic t_check_flips(logic [63:0] base);
    logic [7:0] e = ref_check(base);
    for (int k = 0; k < 8; k++) begin
      apply(base, e ^ (8'h1 << k));
      check_vec("R4 check flip", ref_decode(base, e ^ (8'h1 << k)));
      n_checks++;
      if (ecc_out !== e || bad_ecc_bit !== 3'(k) || !bad_ecc_vld || bad_data_vld) begin
        n_errors++;
        $display("FAIL R4 bit %0d: actual=%h idx=%0d expected=%h idx=%0d", k, ecc_out, bad_ecc_bit, e, k);
      end
    end
  endtask

  task automatic t_double_flips(logic [63:0] base);
    logic [7:0] e = ref_check(base);
    for (int a = 0; a < 64; a += 7) begin
      logic [63:0] w = base ^ (64'h1 << a) ^ (64'h1 << ((a + 13) % 64));
      apply(w, e);
      check_vec("R5 R6 double data flip", ref_decode(w, e));
    end
    for (int k = 0; k < 8; k++) begin
      logic [63:0] w = base ^ (64'h1 << (k * 8 + 3));
      apply(w, e ^ (8'h1 << k));
      check_vec("R5 R6 data plus check flip", ref_decode(w, e ^ (8'h1 << k)));
    end
    for (int k = 0; k < 7; k++) begin
      logic [7:0] ee = e ^ (8'h3 << k);
      apply(base, ee);
      check_vec("R5 double check flip", ref_decode(base, ee));
      n_checks++;
      if (!multi_err || single_err || ecc_out !== ee) begin
        n_errors++;
        $display("FAIL R5 check pair %0d: actual=%b%b %h expected=10 %h", k, multi_err, single_err, ecc_out, ee);
      end
    end
  endtask

  task automatic t_latency();
    logic [63:0] wa = 64'h1357_9bdf_2468_ace0;
    logic [63:0] wb = wa ^ 64'h0000_0100_0000_0000;
    logic [100:0] ea = ref_decode(wa, ref_check(wa));
    apply(wa, ref_check(wa));
    {data_hi, data_lo} = wb;
    #1;
    check_vec("R7 output holds until edge", ea);
    @(posedge clk);
    @(negedge clk);
    check_vec("R7 output after edge", ref_decode(wb, ref_check(wa)));
  endtask

  initial begin
    t_reset();
    t_encode();
    t_data_flips(64'h0);
    t_data_flips(64'hc0de_1234_fedc_ba98);
    t_check_flips(64'h0);
    t_check_flips(64'h7777_0000_ffff_1111);
    t_double_flips(64'ha5a5_5a5a_0f0f_f0f0);
    t_latency();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule